// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a raster display, together with the current pixel column and line inside the visible area and a one-cycle pulse at the start of each frame. Every segment of a line (sync, back porch, visible pixels, front porch) and every segment of a frame (the same four, counted in lines) has its length held in a register as the length minus one. A line always runs sync, back porch, visible, front porch. A frame does the same, counted in lines.

Software reaches the block through a single-cycle register port. A write lands on the clock edge. A read returns the addressed register in the same cycle. A command bit starts and stops scanning. A polarity register picks the asserted level of each strobe and of the pixel data, which passes through while data-enable is asserted and is held at its blank level otherwise. A raw vertical-sync event bit and a mask bit together drive one interrupt line. Timing registers may be rewritten at any moment. The generator copies them into working storage only on a frame boundary, or while stopped, so a frame in progress never changes shape.

Top module: `dtg_top`

## Requirements
- R1: After reset the generator is stopped, every register reads 0, the strobes sit at their deasserted level under active-low polarity (hsync_o, vsync_o, de_o all 1, pix_o all ones), x_o, y_o, frame_start_o and irq_o are 0.
- R2: Each line is hsync (register 7 + 1 cycles), horizontal back porch (register 5 + 1), visible pixels (register 4 + 1), horizontal front porch (register 6 + 1), in that order, with hsync_o asserted only during the first segment.
- R3: Each frame is vsync (register 11 + 1 lines), vertical back porch (register 9 + 1), visible lines (register 8 + 1), vertical front porch (register 10 + 1), in that order, with vsync_o asserted only during the first segment.
- R4: de_o is asserted only on visible pixels of visible lines, where x_o and y_o give the zero-based column and line; elsewhere both are 0.
- R5: Register 1 holds the polarity: bit 0 hsync, bit 1 vsync, bit 2 data-enable, bit 3 pixel data; a 1 makes the signal active high. With bit 3 at 1, pix_o equals pix_i during data-enable and is 0 otherwise; with bit 3 at 0, pix_o is the inverse of pix_i and all ones otherwise.
- R6: Writing 1 to bit 0 of register 0 starts a frame in the cycle after the write; writing 0 drives all strobes to their deasserted level from the cycle after the write, and a later start begins again at the first cycle of a frame.
- R7: frame_start_o is high for exactly the first cycle of each frame, which is also the first cycle of both hsync and vsync.
- R8: Bit 0 of register 3 is set by the start of vsync and is visible the cycle after it. Writing 1 to that bit clears it; writing 0 leaves it unchanged.
- R9: irq_o is high exactly when the status bit of register 3 and bit 0 of register 2 (the mask) are both 1.
- R10: A timing register written during a frame leaves that frame unchanged and takes effect from the next frame.
- R11: Registers 0 to 2 and 4 to 11 read back the last value written, cut to their width: 1 bit for registers 0 and 2, 4 bits for register 1, 16 bits for the timing registers; addresses 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data for rd_addr, same cycle |
| pix_i | input | PIX_W | Pixel data from upstream |
| pix_o | output | PIX_W | Pixel data after polarity and blanking |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | 16 | Visible column, 0 outside the visible area |
| y_o | output | 16 | Visible line, 0 outside the visible area |
| frame_start_o | output | 1 | One-cycle pulse on the first cycle of a frame |
| irq_o | output | 1 | Vertical-sync interrupt |

## Verification
The strobes, x_o, y_o, frame_start_o and pix_o are decoded directly from the counters without a further register. The first frame cycle is therefore the cycle right after the edge that stores the start command, and the bench calls that cycle k = 0. From there it computes the expected values for every later cycle from k, the line length and the frame length. The status bit and irq_o follow one cycle after frame_start_o, and read data follows rd_addr in the same cycle. The bench drives stimulus at the falling edge and samples 1 ns later, so every written value has crossed exactly one rising edge before it is checked. A timing write issued at cycle 5 of a frame is checked against the old shape for the rest of that frame and against the new shape after it.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = CNT_W;
    localparam int NUM_TIM = 8;
    localparam int TIM_SEL_W = $clog2(NUM_TIM);

    // Register map
    localparam logic [ADDR_W-1:0] A_CMD      = 4'd0;
    localparam logic [ADDR_W-1:0] A_POL      = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK     = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT     = 4'd3;
    localparam logic [ADDR_W-1:0] A_TIM_BASE = 4'd4;
    localparam logic [ADDR_W-1:0] A_TIM_LAST = ADDR_W'(int'(A_TIM_BASE) + NUM_TIM - 1);

    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    typedef struct packed {
        logic [CNT_W-1:0] sync_m1;
        logic [CNT_W-1:0] back_m1;
        logic [CNT_W-1:0] act_m1;
        logic [CNT_W-1:0] front_m1;
    } axis_cfg_t;

    typedef struct packed {
        logic data_hi;
        logic de_hi;
        logic vs_hi;
        logic hs_hi;
    } pol_t;

    function automatic logic [CNT_W-1:0] seg_limit(axis_cfg_t c, seg_e s);
        case (s)
            SEG_SYNC: return c.sync_m1;
            SEG_BACK: return c.back_m1;
            SEG_ACT:  return c.act_m1;
            default:  return c.front_m1;
        endcase
    endfunction

    function automatic seg_e seg_next(seg_e s);
        case (s)
            SEG_SYNC: return SEG_BACK;
            SEG_BACK: return SEG_ACT;
            SEG_ACT:  return SEG_FRONT;
            default:  return SEG_SYNC;
        endcase
    endfunction

    // Pin level for an internal "asserted" flag under a polarity bit
    function automatic logic pin_level(logic asserted, logic active_high);
        return asserted ~^ active_high;
    endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stat_set,
    output logic              run,
    output pol_t              pol,
    output logic              mask,
    output logic              stat,
    output axis_cfg_t         h_cfg,
    output axis_cfg_t         v_cfg
);

    logic [CNT_W-1:0] tim_q [NUM_TIM];

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            pol  <= '0;
            mask <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CMD:   run  <= wr_data[0];
                A_POL:   pol  <= pol_t'(wr_data[3:0]);
                A_MASK:  mask <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Raw status: a new event wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= 1'b0;
        end else if (stat_set) begin
            stat <= 1'b1;
        end else if (wr_en && wr_addr == A_STAT && wr_data[0]) begin
            stat <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TIM; i++) tim_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_TIM; i++) begin
                if (wr_addr == ADDR_W'(int'(A_TIM_BASE) + i)) tim_q[i] <= wr_data[CNT_W-1:0];
            end
        end
    end

    // Timing slots: +0 active, +1 back porch, +2 front porch, +3 sync; H then V
    assign h_cfg = '{sync_m1: tim_q[3], back_m1: tim_q[1], act_m1: tim_q[0], front_m1: tim_q[2]};
    assign v_cfg = '{sync_m1: tim_q[7], back_m1: tim_q[5], act_m1: tim_q[4], front_m1: tim_q[6]};

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMD:   rd_data[0]   = run;
            A_POL:   rd_data[3:0] = pol;
            A_MASK:  rd_data[0]   = mask;
            A_STAT:  rd_data[0]   = stat;
            default: begin
                if (rd_addr <= A_TIM_LAST)
                    rd_data[CNT_W-1:0] = tim_q[TIM_SEL_W'(rd_addr - A_TIM_BASE)];
            end
        endcase
    end

endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    logic at_end;

    assign at_end = (cnt == seg_limit(cfg, seg));
    assign last   = at_end && (seg == SEG_FRONT);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            seg <= SEG_SYNC;
            cnt <= '0;
        end else if (step) begin
            if (at_end) begin
                cnt <= '0;
                seg <= seg_next(seg);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PIX_W-1:0]  pix_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [CNT_W-1:0]  x_o,
    output logic [CNT_W-1:0]  y_o,
    output logic              frame_start_o,
    output logic              irq_o
);

    logic             run;
    pol_t             pol;
    logic             mask;
    logic             stat;
    axis_cfg_t        h_cfg_reg, v_cfg_reg;
    axis_cfg_t        h_cfg_s, v_cfg_s;
    seg_e             h_seg, v_seg;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             h_last, v_last, frame_end;
    logic             hs_act, vs_act, de_act;

    dtg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .stat_set (frame_start_o),
        .run      (run),
        .pol      (pol),
        .mask     (mask),
        .stat     (stat),
        .h_cfg    (h_cfg_reg),
        .v_cfg    (v_cfg_reg)
    );

    // Working copy of the timing: refreshed while stopped or on a frame wrap
    assign frame_end = h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cfg_s <= '0;
            v_cfg_s <= '0;
        end else if (!run || frame_end) begin
            h_cfg_s <= h_cfg_reg;
            v_cfg_s <= v_cfg_reg;
        end
    end

    dtg_axis u_haxis (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .step (1'b1),
        .cfg  (h_cfg_s),
        .seg  (h_seg),
        .cnt  (h_cnt),
        .last (h_last)
    );

    dtg_axis u_vaxis (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .step (h_last),
        .cfg  (v_cfg_s),
        .seg  (v_seg),
        .cnt  (v_cnt),
        .last (v_last)
    );

    assign hs_act = run && (h_seg == SEG_SYNC);
    assign vs_act = run && (v_seg == SEG_SYNC);
    assign de_act = run && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);

    assign hsync_o = pin_level(hs_act, pol.hs_hi);
    assign vsync_o = pin_level(vs_act, pol.vs_hi);
    assign de_o    = pin_level(de_act, pol.de_hi);

    assign x_o = de_act ? h_cnt : '0;
    assign y_o = de_act ? v_cnt : '0;

    assign frame_start_o = hs_act && vs_act && (h_cnt == '0) && (v_cnt == '0);

    assign pix_o = de_act ? (pol.data_hi ? pix_i : ~pix_i) : {PIX_W{~pol.data_hi}};

    assign irq_o = stat && mask;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             hs_hi,
    input logic             vs_hi,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             de_act,
    input logic             frame_start_o,
    input logic             irq_o,
    input logic             mask,
    input logic             wr_en,
    input logic [CNT_W-1:0] x_o,
    input logic [CNT_W-1:0] y_o
);

    AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |-> (hsync_o == !hs_hi && vsync_o == !vs_hi)); // R6

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o); // R7

    AST_FS_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (hsync_o == hs_hi && vsync_o == vs_hi)); // R7

    AST_POS_ZERO_BLANK: assert property (@(posedge clk) disable iff (rst)
        !de_act |-> (x_o == '0 && y_o == '0)); // R4

    AST_IRQ_AFTER_VSYNC: assert property (@(posedge clk) disable iff (rst)
        (frame_start_o && mask && !wr_en) |=> irq_o); // R9

endmodule

bind dtg_top dtg_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .run           (run),
    .hs_hi         (pol.hs_hi),
    .vs_hi         (pol.vs_hi),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .de_act        (de_act),
    .frame_start_o (frame_start_o),
    .irq_o         (irq_o),
    .mask          (mask),
    .wr_en         (wr_en),
    .x_o           (x_o),
    .y_o           (y_o)
);

// File: tb/dtg_top_tb.sv
module dtg_top_tb;
    import dtg_pkg::*;

    localparam int PW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [PW-1:0]     pix_i = '0;
    logic [PW-1:0]     pix_o;
    logic              hsync_o, vsync_o, de_o, frame_start_o, irq_o;
    logic [CNT_W-1:0]  x_o, y_o;

    int checks = 0;
    int fails  = 0;
    int cur_pol = 0;

    typedef struct {
        int hs, hb, ha, hf, vs, vb, va, vf;
    } tcfg_t;

    always #4 clk = ~clk;

    dtg_top #(.PIX_W(PW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pix_i(pix_i), .pix_o(pix_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .x_o(x_o), .y_o(y_o),
        .frame_start_o(frame_start_o), .irq_o(irq_o)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int lvl(input bit act, input bit hi);
        return (act == hi) ? 1 : 0;
    endfunction

    function automatic int frame_len(input tcfg_t c);
        return (c.hs + c.hb + c.ha + c.hf + 4) * (c.vs + c.vb + c.va + c.vf + 4);
    endfunction

    task automatic axis_pos(input int p, input int s, input int b, input int a,
                            output int seg, output int off);
        if (p < s + 1) begin seg = 0; off = p; end
        else if (p < s + b + 2) begin seg = 1; off = p - (s + 1); end
        else if (p < s + b + a + 3) begin seg = 2; off = p - (s + b + 2); end
        else begin seg = 3; off = p - (s + b + a + 3); end
    endtask

    task automatic check_idle(input string tag);
        chk_eq({tag, " hsync idle"}, int'(hsync_o), lvl(1'b0, cur_pol[0]));
        chk_eq({tag, " vsync idle"}, int'(vsync_o), lvl(1'b0, cur_pol[1]));
        chk_eq({tag, " de idle"}, int'(de_o), lvl(1'b0, cur_pol[2]));
        chk_eq({tag, " x idle"}, int'(x_o), 0);
        chk_eq({tag, " frame_start idle"}, int'(frame_start_o), 0);
    endtask

    task automatic check_cycle(input int k, input tcfg_t a, input tcfg_t b, input bit torn);
        tcfg_t c;
        int kk, ht, vt, hseg, hoff, vseg, voff;
        bit hs, vs, de, fs;
        logic [PW-1:0] ep;
        kk = k;
        c = a;
        if (k >= frame_len(a)) begin kk = k - frame_len(a); c = b; end
        ht = c.hs + c.hb + c.ha + c.hf + 4;
        vt = c.vs + c.vb + c.va + c.vf + 4;
        axis_pos(kk % ht, c.hs, c.hb, c.ha, hseg, hoff);
        axis_pos((kk / ht) % vt, c.vs, c.vb, c.va, vseg, voff);
        hs = (hseg == 0);
        vs = (vseg == 0);
        de = (hseg == 2) && (vseg == 2);
        fs = (kk % (ht * vt)) == 0;
        if (de) ep = cur_pol[3] ? pix_i : ~pix_i;
        else    ep = cur_pol[3] ? 8'h00 : 8'hFF;
        chk_eq("R2 hsync", int'(hsync_o), lvl(hs, cur_pol[0]));
        chk_eq("R3 vsync", int'(vsync_o), lvl(vs, cur_pol[1]));
        chk_eq("R4 de", int'(de_o), lvl(de, cur_pol[2]));
        chk_eq("R4 x", int'(x_o), de ? hoff : 0);
        chk_eq("R4 y", int'(y_o), de ? voff : 0);
        chk_eq("R7 frame_start", int'(frame_start_o), fs ? 1 : 0);
        chk_eq("R5 pixel", int'(pix_o), int'(ep));
        if (torn && k >= frame_len(a))
            chk_eq("R10 x in retimed frame", int'(x_o), de ? hoff : 0);
    endtask

    task automatic run_cfg(input tcfg_t a, input int pol, input int nfr,
                           input int tear_k, input int tear_ha);
        tcfg_t b;
        int total;
        wr(0, 0);
        #1;
        check_idle("R6 stop");
        wr(4, a.ha); wr(5, a.hb); wr(6, a.hf); wr(7, a.hs);
        wr(8, a.va); wr(9, a.vb); wr(10, a.vf); wr(11, a.vs);
        wr(1, pol);
        cur_pol = pol;
        b = a;
        if (tear_k >= 0) b.ha = tear_ha;
        total = frame_len(a) + (nfr - 1) * frame_len(b) + 3;
        wr(0, 1);
        for (int k = 0; k < total; k++) begin
            pix_i = PW'(k * 37 + 11);
            if (k == tear_k) begin
                wr_en = 1'b1;
                wr_addr = 4'd4;
                wr_data = DATA_W'(tear_ha);
            end
            #1;
            if (k == 0) chk_eq("R6 start at frame begin", int'(frame_start_o), 1);
            check_cycle(k, a, b, tear_k >= 0);
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        tcfg_t c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk_eq("R1 hsync", int'(hsync_o), 1);
        chk_eq("R1 vsync", int'(vsync_o), 1);
        chk_eq("R1 de", int'(de_o), 1);
        chk_eq("R1 pix", int'(pix_o), 255);
        chk_eq("R1 x", int'(x_o), 0);
        chk_eq("R1 y", int'(y_o), 0);
        chk_eq("R1 frame_start", int'(frame_start_o), 0);
        chk_eq("R1 irq", int'(irq_o), 0);
        for (int r = 0; r < 16; r++) begin
            rd_addr = ADDR_W'(r);
            #1;
            chk_eq("R1 register reset value", int'(rd_data), 0);
        end
        @(negedge clk);

        // Register readback and width cut
        for (int r = 4; r < 12; r++) wr(r, 16'hA000 | (r * 3 + 1));
        wr(1, 16'hFFFA);
        wr(2, 16'hFFFE);
        for (int r = 4; r < 12; r++) begin
            rd_addr = ADDR_W'(r);
            #1;
            chk_eq("R11 timing readback", int'(rd_data), 16'hA000 | (r * 3 + 1));
        end
        rd_addr = 4'd1; #1; chk_eq("R11 polarity readback", int'(rd_data), 10);
        rd_addr = 4'd2; #1; chk_eq("R11 mask readback", int'(rd_data), 0);
        rd_addr = 4'd13; #1; chk_eq("R11 unused address", int'(rd_data), 0);
        wr(1, 0);
        cur_pol = 0;

        // Sweep of small configurations
        for (int hs = 0; hs < 2; hs++)
            for (int hai = 0; hai < 2; hai++)
                for (int vb = 0; vb < 2; vb++)
                    for (int pi = 0; pi < 2; pi++) begin
                        c = '{hs: hs, hb: 1, ha: hai * 3, hf: 0, vs: hs, vb: vb, va: 1, vf: 1};
                        run_cfg(c, pi * 15, 2, -1, 0);
                    end
        c = '{hs: 0, hb: 0, ha: 0, hf: 0, vs: 0, vb: 0, va: 0, vf: 0};
        run_cfg(c, 5, 3, -1, 0);
        c = '{hs: 2, hb: 3, ha: 7, hf: 2, vs: 1, vb: 2, va: 4, vf: 2};
        run_cfg(c, 10, 3, 5, 2);

        // Interrupt status and mask
        wr(0, 0);
        rd_addr = 4'd3;
        #1;
        chk_eq("R8 status set by vsync", int'(rd_data), 1);
        chk_eq("R9 irq masked", int'(irq_o), 0);
        wr(3, 0);
        #1;
        chk_eq("R8 write 0 keeps status", int'(rd_data), 1);
        wr(3, 1);
        #1;
        chk_eq("R8 write 1 clears status", int'(rd_data), 0);
        wr(2, 1);
        #1;
        chk_eq("R9 mask without status", int'(irq_o), 0);
        wr(0, 1);
        #1;
        chk_eq("R8 status not yet set", int'(irq_o), 0);
        @(negedge clk);
        #1;
        chk_eq("R9 irq after vsync start", int'(irq_o), 1);
        chk_eq("R8 status visible", int'(rd_data), 1);
        @(negedge clk);
        wr(2, 0);
        #1;
        chk_eq("R9 irq cleared by mask", int'(irq_o), 0);
        chk_eq("R8 status held under mask", int'(rd_data), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule